// File: doc/BRIEF.md
# Debounced System Reset Pulse Generator

This block drives a complementary pair of system reset lines, one active-high and one active-low, from three independent causes. A supply-valid flag from an external comparator forces reset while the supply is bad. An active-low pushbutton, sampled asynchronously, first crosses a synchroniser and a debounce filter before it can request reset. A one-cycle timeout request from a watchdog also forces reset. Every reset is stretched to a guaranteed minimum length, counted in cycles of a free-running clock, by a single down-counter that all three causes share.

The stretch length and the debounce interval are given in milliseconds together with the clock frequency, and are turned into cycle counts at elaboration. Any request seen while a stretch is running reloads the counter, so reset always ends one full interval after the last request. For the button, this means the interval runs from the debounced release, not from the press. A status copy of the reset level and a one-cycle done pulse at the end of reset let a watchdog or a boot sequencer start its work.

Top module: `rstgen_top`

## Requirements
- R1: With N = CLK_HZ/1000 * HOLD_MS, a reset request sampled at clock edge k drives sys_rst_o high after edge k and keeps it high until edge k+N+1, after which it goes low if no further request was sampled; a request sampled during a running stretch restarts this window from its own edge.
- R2: While rst_ni is low the block holds sys_rst_o high and rst_done_o low; after rst_ni rises, reset stays high until the (N+1)th clock edge and then ends.
- R3: When supply_ok_i is low, sys_rst_o is high in the same cycle without waiting for a clock edge, and stays high for the whole time the flag is low plus the N+1 edge stretch that follows the last edge at which it was sampled low.
- R4: button_n_i passes through SYNC_STAGES flip-flops and then a debounce filter with D = CLK_HZ/1000 * DEBOUNCE_MS; a new level is accepted only after the synchronised input has differed from the accepted level on D consecutive edges, so a low pulse of fewer than D cycles causes no reset.
- R5: With SYNC_STAGES = 2, a button press that starts at edge c0 and lasts P >= D cycles makes reset active from edge c0+D+2, holds it for the whole press, and ends it N+1 edges after the debounced release, that is after edge c0+P+D+N+2.
- R6: A one-cycle high pulse on wdt_expire_i starts a reset stretch as in R1.
- R7: sys_rst_n_o is always the complement of sys_rst_o, and rst_active_o always equals sys_rst_o.
- R8: rst_done_o is high for exactly one cycle, in the cycle right after the stretch counter lets reset go low, and is low at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock that times the stretch and the debounce |
| rst_ni | input | 1 | Asynchronous active-low reset of the block's own flip-flops |
| supply_ok_i | input | 1 | Supply-valid flag from the external comparator, high when the supply is good |
| button_n_i | input | 1 | Asynchronous pushbutton level, low while pressed |
| wdt_expire_i | input | 1 | One-cycle timeout request from a watchdog |
| sys_rst_o | output | 1 | System reset, active high |
| sys_rst_n_o | output | 1 | System reset, active low |
| rst_active_o | output | 1 | Status copy of the reset level |
| rst_done_o | output | 1 | One-cycle pulse when reset has ended |

## Verification
The assertions check on every cycle that any request reloads the counter to its full value, that reset stays up while the counter is non-zero, that the supply and watchdog requests raise reset at the next edge, that a held debounced button keeps reset up, that the debounced level changes only when its counter has reached its limit, and that the done pulse is a single cycle on the falling edge of reset. What only the bench's scenarios can show is the complete timing from the port: exact start and end edges of a button reset counted through synchroniser and filter, that short glitches never reach the outputs, the reload when watchdog, supply and button requests overlap in random order, and the combinational response to a falling supply flag.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

   // Converts a time in milliseconds to a count of clock cycles.
   function automatic int unsigned ms_to_cycles(input int unsigned clk_hz,
                                                input int unsigned ms);
      return (clk_hz / 1000) * ms;
   endfunction

   // One bit per reset cause, all sampled by the shared stretch counter.
   typedef struct packed {
      logic supply;
      logic button;
      logic watchdog;
   } rst_src_t;

endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
   parameter int unsigned STAGES = 2,
   parameter bit          INIT   = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rstgen_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= {STAGES{INIT}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstgen_debounce.sv
module rstgen_debounce #(
   parameter int unsigned CYCLES = 1000,
   parameter bit          INIT   = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic level_i,
   output logic level_o
);

   generate
      if (CYCLES == 0) begin : g_bypass
         assign level_o = level_i;
      end else begin : g_filter
         localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
         localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

         logic [CW-1:0] cnt_q;
         logic          lvl_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q <= '0;
               lvl_q <= INIT;
            end else if (level_i == lvl_q) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               lvl_q <= level_i;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign level_o = lvl_q;

         AST_DB_ACCEPT_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (lvl_q != $past(lvl_q)) |-> ($past(cnt_q) == LAST)); // R4
         AST_DB_AGREE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (level_i == lvl_q) |=> (cnt_q == '0)); // R4
      end
   endgenerate

endmodule

// File: rtl/rstgen_stretch.sv
module rstgen_stretch
   import rstgen_pkg::*;
#(
   parameter int unsigned HOLD = 1000
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  rst_src_t req_i,
   output logic     active_o,
   output logic     done_o
);

   localparam int unsigned CW = $clog2(HOLD + 1);
   localparam logic [CW-1:0] FULL = CW'(HOLD);

   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("rstgen_stretch: HOLD must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          act_q;
   logic          done_q;
   logic          any_req;

   assign any_req = |req_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= FULL;
         act_q  <= 1'b1;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (any_req) begin
            cnt_q <= FULL;
            act_q <= 1'b1;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            act_q <= 1'b1;
         end else begin
            act_q  <= 1'b0;
            done_q <= act_q;
         end
      end
   end

   assign active_o = act_q;
   assign done_o   = done_q;

   AST_REQ_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_req |=> (act_q && (cnt_q == FULL))); // R1
   AST_HOLD_WHILE_COUNTING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q != '0) |=> act_q); // R1
   AST_SUPPLY_FORCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i.supply |=> act_q); // R3
   AST_WDT_FORCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i.watchdog |=> act_q); // R6
   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q); // R8
   AST_DONE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |-> (!act_q && $past(act_q))); // R8

endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
   import rstgen_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 100_000_000,
   parameter int unsigned HOLD_MS     = 250,
   parameter int unsigned DEBOUNCE_MS = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic supply_ok_i,
   input  logic button_n_i,
   input  logic wdt_expire_i,
   output logic sys_rst_o,
   output logic sys_rst_n_o,
   output logic rst_active_o,
   output logic rst_done_o
);

   localparam int unsigned HOLD_CYC = ms_to_cycles(CLK_HZ, HOLD_MS);
   localparam int unsigned DEB_CYC  = ms_to_cycles(CLK_HZ, DEBOUNCE_MS);

   generate
      if (CLK_HZ < 1000) begin : g_bad_clk
         $error("rstgen_top: CLK_HZ must be at least 1000");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("rstgen_top: stretch interval rounds to zero cycles");
      end
   endgenerate

   logic     btn_sync;
   logic     btn_level;
   logic     stretch_act;
   rst_src_t req;

   rstgen_sync #(
      .STAGES (SYNC_STAGES),
      .INIT   (1'b1)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (button_n_i),
      .q_o    (btn_sync)
   );

   rstgen_debounce #(
      .CYCLES (DEB_CYC),
      .INIT   (1'b1)
   ) u_debounce (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (btn_sync),
      .level_o (btn_level)
   );

   always_comb begin
      req.supply   = ~supply_ok_i;
      req.button   = ~btn_level;
      req.watchdog = wdt_expire_i;
   end

   rstgen_stretch #(
      .HOLD (HOLD_CYC)
   ) u_stretch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (req),
      .active_o (stretch_act),
      .done_o   (rst_done_o)
   );

   // The supply path bypasses the register so reset rises without a clock edge.
   assign sys_rst_o    = stretch_act | ~supply_ok_i;
   assign sys_rst_n_o  = ~sys_rst_o;
   assign rst_active_o = sys_rst_o;

   AST_BUTTON_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !btn_level |=> rst_active_o); // R5
   AST_DONE_MEANS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_done_o && supply_ok_i) |-> !sys_rst_o); // R8

endmodule

// File: tb/tb_rstgen_top.sv
`timescale 1ns/1ps
module tb_rstgen_top;

   localparam int N = 40;   // HOLD_MS=40 at 1 kHz scaling
   localparam int D = 6;    // DEBOUNCE_MS=6

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr = 1'b1;
   logic btn = 1'b1;
   logic wdt = 1'b0;
   logic sys_rst, sys_rst_n, rst_active, rst_done;

   always #5 clk = ~clk;

   rstgen_top #(
      .CLK_HZ      (1000),
      .HOLD_MS     (40),
      .DEBOUNCE_MS (6),
      .SYNC_STAGES (2)
   ) dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .supply_ok_i  (pwr),
      .button_n_i   (btn),
      .wdt_expire_i (wdt),
      .sys_rst_o    (sys_rst),
      .sys_rst_n_o  (sys_rst_n),
      .rst_active_o (rst_active),
      .rst_done_o   (rst_done)
   );

   int checks = 0;
   int errors = 0;
   int e  = 0;   // edges since release of rst_n
   int dl = 0;   // reset of the stretch ends at this edge (watchdog, supply)
   int bf = 0;   // first edge of the current button window
   int bd = 0;   // end edge of the current button window
   bit prev_act = 1'b1;
   string ctx = "R1";

   function automatic bit model_act(input int ee);
      return (ee < dl) || (ee >= bf && ee < bd);
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at edge %0d: actual=%0d expected=%0d", req, e, act, expv);
      end
   endtask

   // Advance one clock edge and compare every output with the timing model.
   task automatic cyc();
      bit ea;
      bit eo;
      @(posedge clk);
      e++;
      @(negedge clk);
      ea = model_act(e);
      eo = ea || !pwr;
      check(sys_rst == eo, ctx, sys_rst, eo);
      check(sys_rst_n == ~sys_rst, "R7", sys_rst_n, ~sys_rst);
      check(rst_active == sys_rst, "R7", rst_active, sys_rst);
      check(rst_done == (prev_act && !ea), "R8", rst_done, prev_act && !ea);
      prev_act = ea;
   endtask

   task automatic wdt_pulse();
      ctx = "R6";
      wdt = 1'b1;
      dl = imax(dl, e + 1 + N + 1);
      cyc();
      wdt = 1'b0;
   endtask

   task automatic supply_dip(input int len);
      ctx = "R3";
      pwr = 1'b0;
      #1;
      check(sys_rst == 1'b1, "R3", sys_rst, 1);
      check(sys_rst_n == 1'b0, "R3", sys_rst_n, 0);
      for (int i = 0; i < len; i++) begin
         dl = imax(dl, e + 1 + N + 1);
         cyc();
      end
      pwr = 1'b1;
   endtask

   task automatic glitch(input int len);
      ctx = "R4";
      btn = 1'b0;
      repeat (len) cyc();
      btn = 1'b1;
      repeat (3) cyc();
   endtask

   task automatic press(input int len);
      int c0;
      ctx = "R5";
      c0 = e + 1;
      dl = imax(dl, bd);
      bf = c0 + D + 2;
      bd = c0 + len + D + N + 2;
      btn = 1'b0;
      repeat (len) cyc();
      btn = 1'b1;
      repeat (D + 3) cyc();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int pick;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R2: reset state while the block is held in reset
      check(sys_rst == 1'b1, "R2", sys_rst, 1);
      check(sys_rst_n == 1'b0, "R2", sys_rst_n, 0);
      check(rst_done == 1'b0, "R2", rst_done, 0);
      rst_n = 1'b1;
      e = 0;
      dl = N + 1;
      ctx = "R2";
      repeat (N + 6) cyc();

      // R4: glitches up to D-1 cycles never reach the outputs
      glitch(1);
      glitch(D - 1);
      repeat (5) cyc();
      // R5: shortest accepted press and a long press
      press(D);
      repeat (N) cyc();
      press(D + 20);
      repeat (N) cyc();
      // R6 then R1 reload by repeated watchdog pulses inside the stretch
      wdt_pulse();
      repeat (N + 5) cyc();
      wdt_pulse();
      repeat (N / 2) cyc();
      ctx = "R1";
      wdt_pulse();
      repeat (N - 1) cyc();
      wdt_pulse();
      repeat (N + 5) cyc();
      // R3: one-cycle and longer supply dips
      supply_dip(1);
      repeat (N + 5) cyc();
      supply_dip(25);
      repeat (N + 5) cyc();

      // Random mix of all causes, R1 reload across overlapping sources
      for (int it = 0; it < 400; it++) begin
         pick = int'($urandom_range(0, 9));
         case (pick)
            0, 1:    wdt_pulse();
            2:       supply_dip(int'($urandom_range(1, 12)));
            3:       glitch(int'($urandom_range(1, D - 1)));
            4:       press(int'($urandom_range(D, D + 15)));
            default: begin
               ctx = "R1";
               repeat (int'($urandom_range(1, 30))) cyc();
            end
         endcase
      end
      ctx = "R1";
      repeat (2 * N) cyc();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule